// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides an input clock by a programmable ratio of the form 16·M + A, where M is a main count and A is a swallow count. A dual-modulus prescaler, built as ordinary logic clocked by the input signal, divides by 17 for the first A prescaler cycles of each output period and by 16 for the rest. Once per full period the block emits a single-clock pulse. It also drives a divide-by-two copy of that pulse stream, which can be routed to a test pin.

The control side presents a 17-bit division word and a one-cycle load strobe. The word waits in a holding register. It becomes active only when the running period finishes, or at once if the divider is idle. Each period is therefore counted entirely with one ratio, and retuning never produces a short or stretched period. After reset the divider stays silent until a word has been loaded.

Top module: `pswal_divider`

## Requirements
- R1: While reset is high, and afterwards until a word has been loaded, `div_pulse` and `div_half` stay low and no pulse is produced.
- R2: The division word is split as M = `div_word[16:4]` and A = `div_word[3:0]`. For a valid word (M ≥ A, ratio ≥ 240), consecutive pulses are exactly 16·M + A input clocks apart.
- R3: Each pulse on `div_pulse` is high for exactly one input clock.
- R4: If the divider is idle and a word is strobed on input clock edge k, the first pulse is visible after edge k + R + 1, where R = 16·M + A.
- R5: A word loaded during a running period does not alter that period. The new ratio governs every period that starts after the next pulse.
- R6: If several words are loaded within one period, only the last one takes effect at the next period boundary.
- R7: `div_half` toggles on the same edge on which `div_pulse` rises and holds its value at all other edges.
- R8: A reset during operation stops pulse generation and discards both the active and the pending ratio. Pulses resume only after a new load.
- R9: The ratio is correct at both swallow extremes (A = 0 and A = 15) and at the minimum ratio 240 (M = 15, A = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input signal being divided; clocks all state |
| rst | input | 1 | Synchronous active-high reset |
| div_load | input | 1 | One-cycle strobe that captures `div_word` into the holding register |
| div_word | input | 17 | Division word: main count in bits 16:4, swallow count in bits 3:0 |
| div_pulse | output | 1 | One-clock pulse per completed division period (registered) |
| div_half | output | 1 | Output that toggles once per period: the pulse stream divided by two (registered) |

## Verification
The bench builds the block with its default widths: a 13-bit main count, a 4-bit swallow count and a prescaler base of 16. These bring the real 240-to-131071 ratio space within reach. Ratios are kept between 240 and a few thousand so that many periods fit in a short run. The chosen words cover both swallow extremes, a mid-period retune, two loads inside one period and a reset in the middle of a period, and a behavioural model follows the outputs on every clock.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  localparam int PRESCALE_N   = 16;
  localparam int MAIN_BITS    = 13;
  localparam int SWALLOW_BITS = 4;
  localparam int MIN_RATIO    = PRESCALE_N * (PRESCALE_N - 1);
endpackage

// File: rtl/pswal_ratio_reg.sv
module pswal_ratio_reg #(
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              cycle_end,
  output logic              run,
  output logic [WORD_W-1:0] act_word
);
  logic [WORD_W-1:0] pend_word;
  logic              pend_vld;
  logic              take;

  // A pending word is adopted when idle or on the final clock of a period
  assign take = pend_vld && (!run || cycle_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_word <= '0;
      pend_vld  <= 1'b0;
      act_word  <= '0;
      run       <= 1'b0;
    end else begin
      if (take) begin
        act_word <= pend_word;
        run      <= 1'b1;
      end
      if (load) begin
        pend_word <= word_in;
        pend_vld  <= 1'b1;
      end else if (take) begin
        pend_vld  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
  parameter int PRE_N = 16,
  parameter int PC_W  = $clog2(PRE_N + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic mod_hi,
  output logic pc_end
);
  logic [PC_W-1:0] pc;

  // Modulus PRE_N+1 when mod_hi, otherwise PRE_N
  assign pc_end = (pc == (mod_hi ? PC_W'(PRE_N) : PC_W'(PRE_N - 1)));

  always_ff @(posedge clk) begin
    if (rst || clr || pc_end) pc <= '0;
    else                      pc <= pc + 1'b1;
  end
endmodule

// File: rtl/pswal_swallow_ctrl.sv
module pswal_swallow_ctrl #(
  parameter int MAIN_W = 13,
  parameter int SWAL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pc_end,
  input  logic [MAIN_W-1:0] main_ratio,
  input  logic [SWAL_W-1:0] swal_ratio,
  output logic              mod_hi,
  output logic              cycle_end
);
  logic [MAIN_W-1:0] mc;
  logic [SWAL_W-1:0] sc;

  assign mod_hi    = (sc < swal_ratio);
  assign cycle_end = run && pc_end && (mc == main_ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || cycle_end) begin
      mc <= '0;
      sc <= '0;
    end else if (pc_end) begin
      mc <= mc + 1'b1;
      if (mod_hi) sc <= sc + 1'b1;
    end
  end
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider #(
  parameter int MAIN_W = pswal_pkg::MAIN_BITS,
  parameter int SWAL_W = pswal_pkg::SWALLOW_BITS,
  parameter int PRE_N  = pswal_pkg::PRESCALE_N
) (
  input  logic                     clk_in,
  input  logic                     rst,
  input  logic                     div_load,
  input  logic [MAIN_W+SWAL_W-1:0] div_word,
  output logic                     div_pulse,
  output logic                     div_half
);
  localparam int WORD_W = MAIN_W + SWAL_W;
  localparam int PC_W   = $clog2(PRE_N + 2);

  logic              run;
  logic [WORD_W-1:0] act_word;
  logic              pc_end;
  logic              mod_hi;
  logic              cycle_end;
  logic              pre_clr;

  pswal_ratio_reg #(.WORD_W(WORD_W)) u_ratio (
    .clk(clk_in), .rst(rst), .load(div_load), .word_in(div_word),
    .cycle_end(cycle_end), .run(run), .act_word(act_word)
  );

  assign pre_clr = !run || cycle_end;

  pswal_prescaler #(.PRE_N(PRE_N), .PC_W(PC_W)) u_pre (
    .clk(clk_in), .rst(rst), .clr(pre_clr), .mod_hi(mod_hi), .pc_end(pc_end)
  );

  pswal_swallow_ctrl #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_ctrl (
    .clk(clk_in), .rst(rst), .run(run), .pc_end(pc_end),
    .main_ratio(act_word[WORD_W-1:SWAL_W]), .swal_ratio(act_word[SWAL_W-1:0]),
    .mod_hi(mod_hi), .cycle_end(cycle_end)
  );

  always_ff @(posedge clk_in) begin
    if (rst) begin
      div_pulse <= 1'b0;
      div_half  <= 1'b0;
    end else begin
      div_pulse <= cycle_end;
      div_half  <= div_half ^ cycle_end;
    end
  end
endmodule

// File: rtl/pswal_divider_chk.sv
module pswal_divider_chk #(
  parameter int MIN_GAP = pswal_pkg::MIN_RATIO
) (
  input logic clk,
  input logic rst,
  input logic div_pulse,
  input logic div_half
);
  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (div_pulse) begin
      gap  <= 32'd1;
      seen <= 1'b1;
    end else if (gap != 32'hFFFF_FFFF) begin
      gap  <= gap + 32'd1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!div_pulse && !div_half));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  assert_half_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(div_pulse) |-> (div_half != $past(div_half)));

  assert_half_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!div_pulse && !$past(rst)) |-> $stable(div_half));

  assert_min_period_R2: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && seen) |-> ((gap + 32'd1) >= MIN_GAP));
endmodule

bind pswal_divider pswal_divider_chk u_chk (
  .clk(clk_in), .rst(rst), .div_pulse(div_pulse), .div_half(div_half)
);

// File: tb/pswal_divider_test.sv
module pswal_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [16:0] word = '0;
  logic        div_pulse, div_half;

  int    n_chk = 0, n_fail = 0;
  int    cyc = 0, npulse = 0, last_pc = 0, ld_cyc = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference state
  int m_run = 0, m_phase = 0, m_ratio = 0, m_pend = 0, m_pend_v = 0;
  bit m_pulse = 0, m_half = 0, m_endc = 0;

  always #4 clk = ~clk;

  pswal_divider uut (
    .clk_in(clk), .rst(rst), .div_load(load), .div_word(word),
    .div_pulse(div_pulse), .div_half(div_half)
  );

  function automatic int ratio_of(logic [16:0] w);
    return 16 * int'(w[16:4]) + int'(w[3:0]);
  endfunction

  function automatic logic [16:0] mk(int m, int a);
    return {13'(m), 4'(a)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_run = 0; m_pend_v = 0; m_phase = 0; m_pulse = 0; m_half = 0;
    end else begin
      m_endc  = (m_run != 0) && (m_phase == m_ratio - 1);
      m_pulse = m_endc;
      if (m_endc) m_half = !m_half;
      if (m_pend_v != 0 && (m_run == 0 || m_endc)) begin
        m_ratio = m_pend; m_run = 1; m_phase = 0; m_pend_v = 0;
      end else if (m_run != 0) begin
        m_phase = m_endc ? 0 : m_phase + 1;
      end
      if (load) begin m_pend = ratio_of(word); m_pend_v = 1; end
    end
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      n_chk++;
      if (div_pulse !== m_pulse || div_half !== m_half) begin
        n_fail++;
        $display("FAIL %s model: pulse/half act=%b%b exp=%b%b at cycle %0d",
                 cur_req, div_pulse, div_half, m_pulse, m_half, cyc);
      end
      if (div_pulse === 1'b1) begin npulse++; last_pc = cyc; end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL %s watchdog: act=hung exp=finished", cur_req);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(logic [16:0] w);
    @(negedge clk); word = w; load = 1'b1;
    @(negedge clk); load = 1'b0; ld_cyc = cyc;
  endtask

  task automatic next_pulse(output int c);
    int start = npulse;
    while (npulse == start) @(negedge clk);
    c = last_pc;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int c1, c2, c3, c4, c5, c6, c7, c8, c9, c10, c11, cnt;
    int h10, h11;
    idle(4);
    rst = 1'b0;
    // R1: quiet after reset, no load yet
    cur_req = "R1";
    @(negedge clk);
    chk("R1 pulse after reset", int'(div_pulse), 0);
    chk("R1 half after reset", int'(div_half), 0);
    idle(300);
    chk("R1 no pulses before load", npulse, 0);

    // R4 / R9: minimum ratio 240, A = 0
    cur_req = "R4";
    do_load(mk(15, 0));
    next_pulse(c1);
    chk("R4 first pulse latency", c1 - ld_cyc, 241);
    cur_req = "R9";
    next_pulse(c2);
    chk("R9 min ratio 240 period", c2 - c1, 240);

    // R5: mid-period retune to 271 (A = 15)
    cur_req = "R5";
    idle(100);
    do_load(mk(16, 15));
    next_pulse(c3);
    chk("R5 current period keeps old ratio", c3 - c2, 240);
    next_pulse(c4);
    chk("R9 swallow 15 period 271", c4 - c3, 271);
    next_pulse(c5);
    chk("R5 new ratio persists", c5 - c4, 271);

    // R2: larger ratio 4807
    cur_req = "R2";
    do_load(mk(300, 7));
    next_pulse(c6);
    chk("R2 period before switch", c6 - c5, 271);
    next_pulse(c7);
    chk("R2 period 4807", c7 - c6, 4807);

    // R6: two loads in one period, last wins
    cur_req = "R6";
    do_load(mk(15, 10));
    idle(3);
    do_load(mk(62, 8));
    next_pulse(c8);
    chk("R6 running period unaffected", c8 - c7, 4807);
    next_pulse(c9);
    chk("R6 last word wins", c9 - c8, 1000);

    // R8: reset mid-period
    cur_req = "R8";
    idle(50);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    cnt = npulse;
    idle(3000);
    chk("R8 no pulses after reset", npulse - cnt, 0);
    chk("R8 half low after reset", int'(div_half), 0);
    do_load(mk(20, 3));
    next_pulse(c10);
    h10 = int'(div_half);
    chk("R8 restart latency", c10 - ld_cyc, 324);
    cur_req = "R7";
    next_pulse(c11);
    h11 = int'(div_half);
    chk("R2 period 323", c11 - c10, 323);
    chk("R7 half toggles per pulse", h11, 1 - h10);
    cur_req = "R3";
    @(negedge clk);
    chk("R3 pulse one clock wide", int'(div_pulse), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule